// File: doc/BRIEF.md
# Paged GPIO Controller with Edge-Triggered Interrupts

This block is a 48-line general-purpose I/O controller reached over a small 8-bit register bus. The bus has an address, write data, registered read data and separate one-cycle read and write strobes. The lines are grouped into six 8-bit ports. Each port has a drive register that works in open-drain fashion. A 1 in a drive bit asserts the line's output enable. A 0 releases the line so that it can act as an input. Reading a port offset returns the synchronized pin levels of that port, not the drive register.

Only the lowest three ports can interrupt. A page register selects which of three banks appears at the three shared offsets that follow it. The banks are edge polarity, line enable and latched event identification. Each interrupt-capable line has its own edge detector, and its polarity bit picks the rising or the falling direction. An edge on an enabled line sets an identification bit. That bit stays set until software drops the line's enable to 0 and raises it again. A read-only summary register reports which ports hold events, and a single level output signals that any event is pending.

Pins are modelled as an input vector and an output-enable vector. Pad logic is outside this block.

Top module: `gpio_paged_ctrl`

## Requirements
- R1: After reset every drive, polarity, enable and identification bit is 0, the page field is 0, `pin_oe` is 0, `irq_out` is 0, and every offset from 0 to 15 reads 0.
- R2: A write to offset p (0..5) loads the drive byte of port p, and bit b of that byte appears on `pin_oe[8p+b]` from the next cycle. A read of offset p returns the pin levels of port p after a two-flop synchronizer. `pin_oe` never changes in a cycle without a write.
- R3: Offset 7 holds the page field in bits 7:6. Other bits are discarded and read as 0. Page 1 maps the polarity bank to offsets 8, 9 and 10 (ports 0, 1 and 2), page 2 maps the enable bank there, and page 3 maps the identification bank there.
- R4: While the page field is 0, offsets 8..10 read 0 and writes to them change nothing.
- R5: A polarity bit of 1 latches rising edges only. A polarity bit of 0 latches falling edges only.
- R6: A line whose enable bit is 0 never holds an identification bit.
- R7: Writing an enable bit to 0 clears that line's identification bit. An edge detected in the same cycle as that write is not latched, while an edge in that cycle on a line that stays enabled is latched.
- R8: Offset 6 reads bit k (k = 0..2) as 1 when port k has any identification bit set. Bits 7:3 read 0, and writes to offset 6 are ignored.
- R9: `irq_out` is high exactly when any identification bit is set.
- R10: Edges on lines 24..47 never produce an event.
- R11: Writes to the identification page are ignored, and offsets 11..15 read 0 and ignore writes.
- R12: A pin change driven between clock edges is latched into identification on the third rising edge after it. `irq_out` is still low after the second edge and high after the third. Read data is valid after the rising edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin levels, asynchronous to clk |
| pin_oe | output | 48 | Output enable per line (1 = drive) |
| irq_out | output | 1 | Active-high level interrupt |

## Verification
The bench first checks that each polarity setting ignores the opposite edge. A detector that fired on both edges, or with its direction inverted, would latch too early or on the wrong transition. It then lands an enable-clear write in exactly the cycle in which two edges are detected, one on the line being cleared and one on a neighbouring enabled line. A design that cleared too late would keep the cleared line's event, and one that cleared the whole port would lose the neighbour's. It also probes page 0, the read-only summary offset, writes into the identification page and edges on the upper ports. A design that leaked any of these into state would show stale or spurious bits in a later read. The interrupt latency is checked at the exact edge, so a synchronizer one stage short or long is caught.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;
  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_POL  = 2'd1,
    BANK_EN   = 2'd2,
    BANK_ID   = 2'd3
  } bank_e;
endpackage

// File: rtl/gpio_pg_sync.sv
module gpio_pg_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pg_drive.sv
module gpio_pg_drive #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PORT_W-1:0]           wdata,
  output logic [NUM_PORTS*PORT_W-1:0] drive_q
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr && (addr == ADDR_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_q[p*PORT_W +: PORT_W] <= '0;
      else if (hit) drive_q[p*PORT_W +: PORT_W] <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pg_irq_port.sv
module gpio_pg_irq_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] lvl,
  input  logic              pol_wr,
  input  logic              en_wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] en_q,
  output logic [PORT_W-1:0] id_q
);
  logic [PORT_W-1:0] prev_q;
  logic [PORT_W-1:0] edge_hit;
  logic [PORT_W-1:0] en_nx;

  always_comb begin
    en_nx    = en_wr ? wdata : en_q;
    edge_hit = (lvl & ~prev_q & pol_q) | (~lvl & prev_q & ~pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      id_q   <= '0;
    end else begin
      prev_q <= lvl;
      if (pol_wr) pol_q <= wdata;
      en_q <= en_nx;
      // an enable dropping to 0 wins over any edge in the same cycle
      id_q <= en_nx & (id_q | (edge_hit & en_q));
    end
  end
endmodule

// File: rtl/gpio_paged_ctrl.sv
module gpio_paged_ctrl
  import gpio_pg_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic                        irq_out
);
  localparam int LINES     = NUM_PORTS * PORT_W;
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
  localparam int OFF_PEND  = NUM_PORTS;
  localparam int OFF_PAGE  = NUM_PORTS + 1;
  localparam int OFF_BANK  = NUM_PORTS + 2;

  logic [LINES-1:0]     lvl_s;
  logic [1:0]           page_q;
  logic [IRQ_LINES-1:0] pol_all, en_all, id_all;
  logic [IRQ_PORTS-1:0] pend;
  logic [PORT_W-1:0]    rd_mux;

  gpio_pg_sync #(.W(LINES), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_s)
  );

  gpio_pg_drive #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .drive_q(pin_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= 2'd0;
    else if (bus_wr && bus_addr == ADDR_W'(OFF_PAGE)) page_q <= bus_wdata[PORT_W-1 -: 2];
  end

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
    logic sel;
    assign sel = bus_wr && (bus_addr == ADDR_W'(OFF_BANK + p));
    gpio_pg_irq_port #(.PORT_W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl_s[p*PORT_W +: PORT_W]),
      .pol_wr(sel && page_q == BANK_POL),
      .en_wr(sel && page_q == BANK_EN),
      .wdata(bus_wdata),
      .pol_q(pol_all[p*PORT_W +: PORT_W]),
      .en_q(en_all[p*PORT_W +: PORT_W]),
      .id_q(id_all[p*PORT_W +: PORT_W])
    );
    assign pend[p] = |id_all[p*PORT_W +: PORT_W];
  end

  assign irq_out = |pend;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (bus_addr == ADDR_W'(i)) rd_mux = lvl_s[i*PORT_W +: PORT_W];
    if (bus_addr == ADDR_W'(OFF_PEND)) rd_mux[IRQ_PORTS-1:0] = pend;
    if (bus_addr == ADDR_W'(OFF_PAGE)) rd_mux[PORT_W-1 -: 2] = page_q;
    for (int i = 0; i < IRQ_PORTS; i++) begin
      if (bus_addr == ADDR_W'(OFF_BANK + i)) begin
        case (page_q)
          BANK_POL: rd_mux = pol_all[i*PORT_W +: PORT_W];
          BANK_EN:  rd_mux = en_all[i*PORT_W +: PORT_W];
          BANK_ID:  rd_mux = id_all[i*PORT_W +: PORT_W];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_paged_ctrl_chk.sv
module gpio_paged_ctrl_chk #(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [PORT_W-1:0]             bus_wdata,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [PORT_W-1:0]             bus_rdata,
  input logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
  input logic                          irq_out,
  input logic [1:0]                    page_q,
  input logic [IRQ_PORTS*PORT_W-1:0]   en_all,
  input logic [IRQ_PORTS*PORT_W-1:0]   id_all
);
  localparam int OFF_PEND = NUM_PORTS;
  localparam int OFF_BANK = NUM_PORTS + 2;

  a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe));

  a_r6_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (id_all & ~en_all) == '0);

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (id_all != '0));

  a_r4_page0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && page_q == 2'd0 && bus_addr >= ADDR_W'(OFF_BANK)
     && bus_addr < ADDR_W'(OFF_BANK + IRQ_PORTS)) |=> bus_rdata == '0);

  a_r8_pending_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFF_PEND)) |=> bus_rdata[PORT_W-1:IRQ_PORTS] == '0);

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_clr
    a_r7_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_q == 2'd2 && bus_addr == ADDR_W'(OFF_BANK + p))
      |=> (id_all[p*PORT_W +: PORT_W] & ~$past(bus_wdata)) == '0);
  end
endmodule

bind gpio_paged_ctrl gpio_paged_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
  .irq_out(irq_out), .page_q(page_q), .en_all(en_all), .id_all(id_all)
);

// File: tb/gpio_paged_ctrl_tb.sv
module gpio_paged_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_oe;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_paged_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // behavioural reference
  logic [7:0]  m_drv [6];
  logic [1:0]  m_page;
  logic [23:0] m_pol, m_en, m_id;
  logic [47:0] m_s1, m_s2, m_prev;
  logic [7:0]  m_rdata;

  function automatic logic [7:0] m_read(input logic [3:0] a);
    int ai = int'(a);
    if (ai < 6) return m_s2[ai*8 +: 8];
    if (ai == 6) return {5'd0, |m_id[23:16], |m_id[15:8], |m_id[7:0]};
    if (ai == 7) return {m_page, 6'd0};
    if (ai >= 8 && ai <= 10) begin
      case (m_page)
        2'd1: return m_pol[(ai-8)*8 +: 8];
        2'd2: return m_en[(ai-8)*8 +: 8];
        2'd3: return m_id[(ai-8)*8 +: 8];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_drv[i] = 8'h00;
      m_page = 0; m_pol = 0; m_en = 0; m_id = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rdata = 0;
    end else begin
      logic [23:0] ev, en_new;
      int ai;
      ai = int'(bus_addr);
      if (bus_rd) m_rdata = m_read(bus_addr);
      ev = '0;
      for (int k = 0; k < 24; k++)
        if (m_pol[k] ? (m_s2[k] && !m_prev[k]) : (!m_s2[k] && m_prev[k])) ev[k] = 1'b1;
      en_new = m_en;
      if (bus_wr) begin
        if (ai < 6) m_drv[ai] = bus_wdata;
        if (ai == 7) m_page = bus_wdata[7:6];
        if (ai >= 8 && ai <= 10 && m_page == 2'd1) m_pol[(ai-8)*8 +: 8] = bus_wdata;
        if (ai >= 8 && ai <= 10 && m_page == 2'd2) en_new[(ai-8)*8 +: 8] = bus_wdata;
      end
      m_id = en_new & (m_id | (ev & m_en));
      m_en = en_new;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the reference (R2, R9, R12)
  always @(negedge clk) begin
    if (!done) begin
      logic [47:0] oe_m;
      for (int i = 0; i < 6; i++) oe_m[i*8 +: 8] = m_drv[i];
      chk("model R2 pin_oe", pin_oe, oe_m);
      chk("model R9 irq_out", {47'd0, irq_out}, {47'd0, |m_id});
      chk("model R12 rdata", {40'd0, bus_rdata}, {40'd0, m_rdata});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, {40'd0, bus_rdata}, {40'd0, exp});
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 pin_oe", pin_oe, 48'd0);
    chk("R1 irq_out", {47'd0, irq_out}, 48'd0);
    for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1 reset read");

    wr(4'd0, 8'hA5); chk("R2 drive port0", {40'd0, pin_oe[7:0]}, 48'hA5);
    wr(4'd5, 8'h3C); chk("R2 drive port5", {40'd0, pin_oe[47:40]}, 48'h3C);
    wr(4'd0, 8'h00); chk("R2 release port0", {40'd0, pin_oe[7:0]}, 48'h00);
    pin_in = 48'h123456_789ABC;
    idle(2);
    rd(4'd0, 8'hBC, "R2 pin read port0");
    rd(4'd5, 8'h12, "R2 pin read port5");
    pin_in = '0;
    idle(4);

    wr(4'd7, 8'hFF); rd(4'd7, 8'hC0, "R3 page readback");
    wr(4'd7, 8'h00); wr(4'd8, 8'hFF); rd(4'd8, 8'h00, "R4 page0 read");
    wr(4'd7, 8'h40); rd(4'd8, 8'h00, "R4 page0 write ignored");
    wr(4'd8, 8'h0F); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    rd(4'd8, 8'h0F, "R3 polarity bank");
    wr(4'd7, 8'h80); wr(4'd8, 8'hFF); wr(4'd9, 8'h01); wr(4'd10, 8'hFF);
    rd(4'd8, 8'hFF, "R3 enable bank");
    wr(4'd7, 8'hC0);
    chk("R9 idle irq", {47'd0, irq_out}, 48'd0);

    pin_in[7:0] = 8'h0F;
    idle(2); chk("R12 irq after 2 edges", {47'd0, irq_out}, 48'd0);
    idle(1); chk("R12 irq after 3 edges", {47'd0, irq_out}, 48'd1);
    rd(4'd8, 8'h0F, "R5 rising latched");
    pin_in[7:0] = 8'h00; idle(4);
    rd(4'd8, 8'h0F, "R5 falling ignored on rising lines");
    pin_in[7:0] = 8'hF0; idle(4);
    rd(4'd8, 8'h0F, "R5 rising ignored on falling lines");
    pin_in[7:0] = 8'h00; idle(4);
    rd(4'd8, 8'hFF, "R5 falling latched");

    rd(4'd6, 8'h01, "R8 pending port0");
    wr(4'd6, 8'hFF); rd(4'd6, 8'h01, "R8 pending write ignored");
    wr(4'd8, 8'h00); rd(4'd8, 8'hFF, "R11 id write ignored");
    wr(4'd12, 8'hFF); rd(4'd12, 8'h00, "R11 high offset");

    wr(4'd7, 8'h80); wr(4'd8, 8'hFE); wr(4'd8, 8'hFF); wr(4'd7, 8'hC0);
    rd(4'd8, 8'hFE, "R7 toggle clears line0");

    pin_in[15:8] = 8'hFF; idle(4);
    rd(4'd9, 8'h01, "R6 only enabled line latched");
    rd(4'd6, 8'h03, "R8 pending ports0-1");

    pin_in[47:24] = 24'hFFFFFF; idle(4);
    pin_in[47:24] = 24'h000000; idle(4);
    rd(4'd6, 8'h03, "R10 upper ports no event");

    wr(4'd7, 8'h80);
    pin_in[17:16] = 2'b11;
    idle(2);
    wr(4'd10, 8'hFE);
    wr(4'd10, 8'hFF); wr(4'd7, 8'hC0);
    rd(4'd10, 8'h02, "R7 same-cycle edge vs clear");
    chk("R9 irq while pending", {47'd0, irq_out}, 48'd1);

    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    chk("R9 irq dropped", {47'd0, irq_out}, 48'd0);
    wr(4'd7, 8'hC0);
    rd(4'd6, 8'h00, "R8 pending cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule